// File: doc/BRIEF.md
# Serial Programming Front End for a Two-Register Synthesizer Control Block

This block takes a slow, bit-serial programming stream and turns it into the divider settings and control flags of a frequency synthesizer. One shared serial path feeds two holding buffers. A select pin decides which buffer each shifted bit enters. The 20-bit frequency buffer becomes active on a rising edge of its commit strobe. The 8-bit control buffer becomes active when the select pin falls. All four serial pins are asynchronous to the system clock. Each one is passed through a synchronizer and edge-detected before any action is taken.

A mode pin can switch the divider values over to parallel input pins. In that mode the prescaler bypass flag is held off. The committed control word sets power-down, counter-load and an observation output that can show one of three internal divider signals. The control word applies only while the active-low enable pin is low. All pins are plain level signals. There is no valid/ready stream at this edge, because the serial protocol has no means of back-pressure, and a commit always takes effect.

Top module: `cfg_serial_front`

## Requirements
- R1: With `par_mode` low, 20 bits shifted LSB first (B0 first) on rising `ser_clk` edges while `enh_sel` is low are applied on a rising edge of `freq_strobe`. The decoded fields are: B0=R[5], B1=R[4], B2=M[8], B3=M[7], B4=bypass, B5..B11=M[6]..M[0], B12..B15=R[3]..R[0], B16..B19=A[3]..A[0].
- R2: Shifting bits does not change the frequency outputs. They change only after a `freq_strobe` rising edge.
- R3: Bits shifted while `enh_sel` is high enter only the 8-bit control buffer, which is applied on a falling edge of `enh_sel`. The frequency buffer is left untouched, so a later `freq_strobe` with no new bits re-applies the previous word.
- R4: With `par_mode` high, `cnt_r`, `cnt_m` and `cnt_a` follow `par_r`, `par_m` and `par_a`, and `bypass` is 0, whatever word was committed.
- R5: While `ctl_enable_n` is high, `pwr_down`, `cnt_load` and `mon_out` are all 0.
- R6: Control word bits: bit2 selects the main-divider pulse, bit3 is power-down, bit4 is counter load, bit5 selects the modulus select, and bit6 selects the reference-divider pulse. `mon_out` takes the first selected source in the order main-divider, modulus select, reference-divider, and is 0 when none is selected.
- R7: While power-down is active, the serial path still shifts and commits new frequency words.
- R8: After reset, all outputs are 0.
- R9: If more than 20 bits are shifted before a commit, only the last 20 are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock, sampled for rising edges |
| freq_strobe | input | 1 | Frequency commit strobe (rising edge) |
| enh_sel | input | 1 | Buffer select; falling edge commits the control word |
| par_mode | input | 1 | 1 = divider values taken from parallel pins |
| ctl_enable_n | input | 1 | Active-low enable for the control word |
| par_r | input | 6 | Parallel reference divider value |
| par_m | input | 9 | Parallel main counter value |
| par_a | input | 4 | Parallel swallow counter value |
| main_div_pulse | input | 1 | Main-divider output, an observation source |
| modsel | input | 1 | Modulus select, an observation source |
| ref_div_pulse | input | 1 | Reference-divider output, an observation source |
| cnt_r | output | 6 | Active reference divider value |
| cnt_m | output | 9 | Active main counter value |
| cnt_a | output | 4 | Active swallow counter value |
| bypass | output | 1 | Prescaler bypass |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Continuous counter load |
| mon_out | output | 1 | Observation output |

## Verification
The hardest case to reach is a buffer that was filled and must stay unused. Examples are the frequency buffer after a control-word load, and a buffer holding extra leading bits. The stimulus first commits one frequency word and then shifts a full control word. It then pulses `freq_strobe` with no new bits, so only an untouched buffer gives back the earlier word. A later 24-bit stream with four junk bits in front shows which bits the shift window kept.

// File: rtl/cfgif_pkg.sv
package cfgif_pkg;
  localparam int FREQ_W = 20;
  localparam int CTRL_W = 8;
  localparam int R_W    = 6;
  localparam int M_W    = 9;
  localparam int A_W    = 4;

  localparam int CB_MAIN = 2;
  localparam int CB_PD   = 3;
  localparam int CB_LOAD = 4;
  localparam int CB_MSEL = 5;
  localparam int CB_REF  = 6;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           byp;
  } freq_fields_t;

  // Interleaved field mapping of the committed word
  function automatic freq_fields_t unpack_freq(input logic [FREQ_W-1:0] w);
    freq_fields_t f;
    f.r   = {w[0], w[1], w[12], w[13], w[14], w[15]};
    f.m   = {w[2], w[3], w[5], w[6], w[7], w[8], w[9], w[10], w[11]};
    f.a   = {w[16], w[17], w[18], w[19]};
    f.byp = w[4];
    return f;
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/shift_buf.sv
module shift_buf #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {din, q[W-1:1]};

  // R2
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/mon_mux.sv
module mon_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_main,
  input  logic sel_msel,
  input  logic sel_ref,
  input  logic src_main,
  input  logic src_msel,
  input  logic src_ref,
  output logic y
);
  logic [2:0] grant;

  always_comb begin
    grant = 3'b000;
    if (sel_main)      grant[0] = 1'b1;
    else if (sel_msel) grant[1] = 1'b1;
    else if (sel_ref)  grant[2] = 1'b1;
  end

  assign y = (grant[0] & src_main) | (grant[1] & src_msel) | (grant[2] & src_ref);

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/cfg_serial_front.sv
module cfg_serial_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_din,
  input  logic       ser_clk,
  input  logic       freq_strobe,
  input  logic       enh_sel,
  input  logic       par_mode,
  input  logic       ctl_enable_n,
  input  logic [5:0] par_r,
  input  logic [8:0] par_m,
  input  logic [3:0] par_a,
  input  logic       main_div_pulse,
  input  logic       modsel,
  input  logic       ref_div_pulse,
  output logic [5:0] cnt_r,
  output logic [8:0] cnt_m,
  output logic [3:0] cnt_a,
  output logic       bypass,
  output logic       pwr_down,
  output logic       cnt_load,
  output logic       mon_out
);
  import cfgif_pkg::*;

  logic din_lvl, din_r, din_f;
  logic sck_lvl, sck_rise, sck_f;
  logic fst_lvl, f_commit, fst_f;
  logic sel_lvl, sel_r, c_commit;

  sync_edge #(.STAGES(SYNC_STAGES)) u_sync_din (.clk(clk), .rst_n(rst_n), .async_in(ser_din),
    .level(din_lvl), .rise(din_r), .fall(din_f));
  sync_edge #(.STAGES(SYNC_STAGES)) u_sync_sck (.clk(clk), .rst_n(rst_n), .async_in(ser_clk),
    .level(sck_lvl), .rise(sck_rise), .fall(sck_f));
  sync_edge #(.STAGES(SYNC_STAGES)) u_sync_fst (.clk(clk), .rst_n(rst_n), .async_in(freq_strobe),
    .level(fst_lvl), .rise(f_commit), .fall(fst_f));
  sync_edge #(.STAGES(SYNC_STAGES)) u_sync_sel (.clk(clk), .rst_n(rst_n), .async_in(enh_sel),
    .level(sel_lvl), .rise(sel_r), .fall(c_commit));

  logic [FREQ_W-1:0] fbuf, freq_q;
  logic [CTRL_W-1:0] cbuf, ctrl_q;

  shift_buf #(.W(FREQ_W)) u_fbuf (.clk(clk), .rst_n(rst_n),
    .shift_en(sck_rise & ~sel_lvl), .din(din_lvl), .q(fbuf));
  shift_buf #(.W(CTRL_W)) u_cbuf (.clk(clk), .rst_n(rst_n),
    .shift_en(sck_rise & sel_lvl), .din(din_lvl), .q(cbuf));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        freq_q <= '0;
    else if (f_commit) freq_q <= fbuf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ctrl_q <= '0;
    else if (c_commit) ctrl_q <= cbuf;

  freq_fields_t ff;
  assign ff = unpack_freq(freq_q);

  always_comb begin
    if (par_mode) begin
      cnt_r  = par_r;
      cnt_m  = par_m;
      cnt_a  = par_a;
      bypass = 1'b0;
    end else begin
      cnt_r  = ff.r;
      cnt_m  = ff.m;
      cnt_a  = ff.a;
      bypass = ff.byp;
    end
  end

  logic [CTRL_W-1:0] ctrl_eff;
  assign ctrl_eff = ctl_enable_n ? '0 : ctrl_q;
  assign pwr_down = ctrl_eff[CB_PD];
  assign cnt_load = ctrl_eff[CB_LOAD];

  mon_mux u_mux (.clk(clk), .rst_n(rst_n),
    .sel_main(ctrl_eff[CB_MAIN]), .sel_msel(ctrl_eff[CB_MSEL]), .sel_ref(ctrl_eff[CB_REF]),
    .src_main(main_div_pulse), .src_msel(modsel), .src_ref(ref_div_pulse), .y(mon_out));

  // R2
  freq_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_q) |-> $past(f_commit));

  // R3
  ctrl_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(c_commit));

  // R5
  gated_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enable_n |-> !mon_out);
endmodule

// File: tb/sim_cfg_serial_front.sv
module sim_cfg_serial_front;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic ser_din = 0, ser_clk = 0, freq_strobe = 0, enh_sel = 0, par_mode = 0, ctl_enable_n = 0;
  logic [5:0] par_r = 0;
  logic [8:0] par_m = 0;
  logic [3:0] par_a = 0;
  logic main_div_pulse = 0, modsel = 0, ref_div_pulse = 0;
  logic [5:0] cnt_r;
  logic [8:0] cnt_m;
  logic [3:0] cnt_a;
  logic bypass, pwr_down, cnt_load, mon_out;

  always #(CLK_P/2) clk = ~clk;

  cfg_serial_front u0 (.clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
    .freq_strobe(freq_strobe), .enh_sel(enh_sel), .par_mode(par_mode), .ctl_enable_n(ctl_enable_n),
    .par_r(par_r), .par_m(par_m), .par_a(par_a), .main_div_pulse(main_div_pulse), .modsel(modsel),
    .ref_div_pulse(ref_div_pulse), .cnt_r(cnt_r), .cnt_m(cnt_m), .cnt_a(cnt_a), .bypass(bypass),
    .pwr_down(pwr_down), .cnt_load(cnt_load), .mon_out(mon_out));

  typedef struct {
    string       req;
    logic [22:0] vec;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model of committed state
  logic [5:0] m_r = 0;
  logic [8:0] m_m = 0;
  logic [3:0] m_a = 0;
  logic       m_b = 0;
  logic [7:0] m_c = 0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic ser_bit(input logic b);
    ser_din = b; tick(4);
    ser_clk = 1; tick(4);
    ser_clk = 0; tick(3);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) ser_bit(w[i]);
  endtask

  function automatic logic [19:0] enc_freq(input logic [5:0] r, input logic [8:0] m,
                                           input logic [3:0] a, input logic pb);
    logic [19:0] w;
    w[0] = r[5]; w[1] = r[4]; w[2] = m[8]; w[3] = m[7]; w[4] = pb;
    for (int k = 0; k < 7; k++) w[5+k] = m[6-k];
    for (int k = 0; k < 4; k++) w[12+k] = r[3-k];
    for (int k = 0; k < 4; k++) w[16+k] = a[3-k];
    return w;
  endfunction

  task automatic strobe_freq();
    freq_strobe = 1; tick(5);
    freq_strobe = 0; tick(5);
  endtask

  task automatic load_freq(input logic [5:0] r, input logic [8:0] m, input logic [3:0] a, input logic pb);
    enh_sel = 0; tick(5);
    shift_bits({12'h0, enc_freq(r, m, a, pb)}, 20);
    strobe_freq();
    m_r = r; m_m = m; m_a = a; m_b = pb;
  endtask

  task automatic load_ctrl(input logic [7:0] c);
    enh_sel = 1; tick(5);
    shift_bits({24'h0, c}, 8);
    enh_sel = 0; tick(6);
    m_c = c;
  endtask

  task automatic expect_now(input string req);
    exp_t e;
    logic [7:0] ce;
    logic mo;
    ce = ctl_enable_n ? 8'h00 : m_c;
    if (ce[2])      mo = main_div_pulse;
    else if (ce[5]) mo = modsel;
    else if (ce[6]) mo = ref_div_pulse;
    else            mo = 1'b0;
    e.req = req;
    if (par_mode) e.vec = {par_r, par_m, par_a, 1'b0, ce[3], ce[4], mo};
    else          e.vec = {m_r, m_m, m_a, m_b, ce[3], ce[4], mo};
    exp_q.push_back(e);
    tick(1);
  endtask

  // monitor: pops and compares at falling edges
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [22:0] act;
      e = exp_q.pop_front();
      act = {cnt_r, cnt_m, cnt_a, bypass, pwr_down, cnt_load, mon_out};
      n_chk++;
      if (act !== e.vec) begin
        n_fail++;
        $display("FAIL %s actual=%06h expected=%06h", e.req, act, e.vec);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1; tick(3);
    expect_now("R8 reset");

    // R1 / R2: shift without commit leaves outputs alone
    enh_sel = 0; tick(5);
    shift_bits({12'h0, enc_freq(6'h2A, 9'h155, 4'd9, 1'b0)}, 20);
    expect_now("R2 no commit yet");
    strobe_freq();
    m_r = 6'h2A; m_m = 9'h155; m_a = 4'd9; m_b = 0;
    expect_now("R1 word A");

    load_freq(6'd63, 9'd1, 4'd0, 1'b1);
    expect_now("R1 word B bypass");
    load_freq(6'h15, 9'h0AA, 4'hF, 1'b0);
    expect_now("R1 word C");

    // R3: control word load, freq outputs untouched, not applied before fall
    enh_sel = 1; tick(5);
    shift_bits({24'h0, 8'b0001_1000}, 8);
    expect_now("R3 before select fall");
    enh_sel = 0; tick(6);
    m_c = 8'b0001_1000;
    expect_now("R3 control applied");
    strobe_freq();
    expect_now("R3 freq buffer untouched");

    // R7: programming still works during power-down
    load_freq(6'd7, 9'd300, 4'd5, 1'b0);
    expect_now("R7 load during power-down");

    // R9: extra leading bits dropped
    enh_sel = 0; tick(5);
    shift_bits({8'h0, enc_freq(6'd33, 9'd77, 4'd3, 1'b1), 4'b1011}, 24);
    strobe_freq();
    m_r = 6'd33; m_m = 9'd77; m_a = 4'd3; m_b = 1;
    expect_now("R9 last 20 bits");

    // R6: priority
    load_ctrl(8'b0110_0100);
    main_div_pulse = 0; modsel = 1; ref_div_pulse = 1; tick(1);
    expect_now("R6 main wins low");
    main_div_pulse = 1; tick(1);
    expect_now("R6 main wins high");
    load_ctrl(8'b0110_0000);
    main_div_pulse = 1; modsel = 0; ref_div_pulse = 1; tick(1);
    expect_now("R6 msel over ref");
    load_ctrl(8'b0100_0000);
    expect_now("R6 ref only");
    load_ctrl(8'b1000_0011);
    expect_now("R6 none selected");

    // R5: gating
    load_ctrl(8'b0011_1100);
    expect_now("R5 enabled");
    ctl_enable_n = 1; tick(1);
    expect_now("R5 gated");
    ctl_enable_n = 0; tick(1);

    // R4: parallel mode
    par_r = 6'd9; par_m = 9'd400; par_a = 4'd12; par_mode = 1; tick(1);
    expect_now("R4 parallel values");
    par_r = 6'd0; par_m = 9'd1; par_a = 4'd0; tick(1);
    expect_now("R4 parallel edge values");
    par_mode = 0; tick(1);
    expect_now("R4 back to serial");

    tick(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule